// File: doc/BRIEF.md
# Iterative Divider with Defined Zero-Divisor Result

This block divides a double-width dividend by a single-width divisor over several clock cycles. It returns both the quotient and the remainder, packed into one double-width word. A two-bit size select picks the operand width: a half-width divisor against a full-width dividend, or a full-width divisor against a double-width dividend. A third, wider request is refused. A sign select switches between unsigned and two's complement division. Signed division truncates toward zero, and the remainder takes the sign of the dividend.

A caller raises `start` for one cycle with the operands held steady. `busy` then stays high while a restoring shift-subtract loop produces one quotient bit per cycle. `done` pulses for one cycle together with the packed result, the overflow flag and the illegal-request flag.

A zero divisor does not stop the block. It produces a defined word: the quotient field is the bitwise inverse of the dividend's upper half, the remainder field is the dividend's lower half, and overflow is raised.

Top module: `zdiv_unit`

## Requirements
- R1: `size_sel` value 00 selects half mode: the divisor is `divisor[OP_W/2-1:0]` and the dividend is `dividend[OP_W-1:0]`, and any higher input bits are ignored. Value 01 selects full mode: the divisor is `divisor[OP_W-1:0]` and the dividend is all of `dividend`. With n the operand width, the result holds the remainder in bits [2n-1:n] and the quotient in bits [n-1:0]. In half mode, result bits above OP_W-1 are zero.
- R2: With `signed_sel`=0 and a non-zero divisor whose true quotient fits in n bits, the fields hold the exact unsigned quotient and remainder, and overflow is 0.
- R3: With `signed_sel`=1, the operands are two's complement, the quotient is truncated toward zero, and the remainder has the sign of the dividend (or is zero).
- R4: If the n-bit divisor is zero, the quotient field is the inverse of dividend bits [2n-1:n], the remainder field is dividend bits [n-1:0], and overflow is 1. This holds in both sign modes.
- R5: If the true quotient does not fit in n bits (unsigned range, or signed range in signed mode), overflow is 1 and the fields hold the true quotient and remainder truncated to n bits. This includes the most negative dividend divided by -1.
- R6: `size_sel` values 10 and 11 are illegal. `done` pulses in the cycle after `start` with `illegal`=1 and `ovf`=0, `busy` never rises, and `result` keeps its previous value.
- R7: For a legal request, `busy` is high from the cycle after `start` for exactly 2n+1 cycles. `done` is high for exactly one cycle, the one in which `busy` has just fallen.
- R8: `start` is ignored while `busy` is high. The result reflects the operands captured at the accepted start.
- R9: After reset, `busy`, `done`, `ovf`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when not busy |
| size_sel_i | input | 2 | 00 half mode, 01 full mode, 10/11 illegal |
| signed_sel_i | input | 1 | 1 = two's complement division |
| dividend_i | input | 2*OP_W | Dividend |
| divisor_i | input | OP_W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2*OP_W | Remainder high, quotient low |
| ovf_o | output | 1 | Zero divisor or quotient overflow |
| illegal_o | output | 1 | Refused size request |

## Verification
The bench builds the divider with the default OP_W of 16. This gives both loop lengths (16 and 32 iterations), an 8-bit divisor against a 16-bit dividend, and a 16-bit divisor against a full 32-bit dividend. At this width the bench's 64-bit integer model holds the most negative 32-bit dividend exactly, so the sign-extreme overflow cases in both modes can be compared bit for bit. Random operands are mixed with forced zero and tiny divisors, so that overflow, the zero rule and ordinary results all occur in each size and sign mode.

// File: rtl/zdiv_pkg.sv
package zdiv_pkg;
  typedef enum logic [1:0] {
    SZ_HALF = 2'b00,
    SZ_FULL = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;
endpackage

// File: rtl/zdiv_sign_prep.sv
module zdiv_sign_prep #(
  parameter int OP_W = 16
) (
  input  logic              narrow,
  input  logic              sgn,
  input  logic [2*OP_W-1:0] dividend,
  input  logic [OP_W-1:0]   divisor,
  output logic [2*OP_W-1:0] dvd_mag,
  output logic [OP_W-1:0]   dvs_mag,
  output logic              neg_q,
  output logic              neg_r,
  output logic              zero_div
);
  localparam int HALF = OP_W / 2;
  localparam int DW   = 2 * OP_W;
  localparam logic [DW-1:0]   ONE_D = DW'(1);
  localparam logic [OP_W-1:0] ONE_O = OP_W'(1);

  logic [DW-1:0]   dvd_ext;
  logic [OP_W-1:0] dvs_ext;
  logic            dvd_neg, dvs_neg;

  always_comb begin
    if (narrow) begin
      dvd_ext = sgn ? {{OP_W{dividend[OP_W-1]}}, dividend[OP_W-1:0]}
                    : {{OP_W{1'b0}}, dividend[OP_W-1:0]};
      dvs_ext = sgn ? {{HALF{divisor[HALF-1]}}, divisor[HALF-1:0]}
                    : {{HALF{1'b0}}, divisor[HALF-1:0]};
    end else begin
      dvd_ext = dividend;
      dvs_ext = divisor;
    end
    dvd_neg  = sgn & dvd_ext[DW-1];
    dvs_neg  = sgn & dvs_ext[OP_W-1];
    dvd_mag  = dvd_neg ? (~dvd_ext + ONE_D) : dvd_ext;
    dvs_mag  = dvs_neg ? (~dvs_ext + ONE_O) : dvs_ext;
    neg_q    = dvd_neg ^ dvs_neg;
    neg_r    = dvd_neg;
    zero_div = (dvs_ext == '0);
  end
endmodule

// File: rtl/zdiv_core.sv
module zdiv_core #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              narrow,
  input  logic [2*OP_W-1:0] dvd_mag,
  input  logic [OP_W-1:0]   dvs_mag,
  output logic [2*OP_W-1:0] quot,
  output logic [OP_W-1:0]   rem
);
  localparam int DW = 2 * OP_W;

  logic [DW-1:0]   qsr_q;
  logic [OP_W-1:0] rem_q;
  logic [OP_W-1:0] div_q;
  logic [OP_W:0]   shifted;
  logic [OP_W:0]   diff;
  logic            ge;

  always_comb begin
    shifted = {rem_q, qsr_q[DW-1]};
    ge      = shifted >= {1'b0, div_q};
    diff    = shifted - {1'b0, div_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qsr_q <= '0;
      rem_q <= '0;
      div_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      div_q <= dvs_mag;
      qsr_q <= narrow ? {dvd_mag[OP_W-1:0], {OP_W{1'b0}}} : dvd_mag;
    end else if (step) begin
      rem_q <= ge ? diff[OP_W-1:0] : shifted[OP_W-1:0];
      qsr_q <= {qsr_q[DW-2:0], ge};
    end
  end

  assign quot = qsr_q;
  assign rem  = rem_q;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (rem_q < div_q)); // R2
endmodule

// File: rtl/zdiv_sign_fix.sv
module zdiv_sign_fix #(
  parameter int OP_W = 16
) (
  input  logic              narrow,
  input  logic              sgn,
  input  logic              neg_q,
  input  logic              neg_r,
  input  logic              zero_div,
  input  logic [2*OP_W-1:0] raw_dvd,
  input  logic [2*OP_W-1:0] qmag,
  input  logic [OP_W-1:0]   rmag,
  output logic [2*OP_W-1:0] res,
  output logic              ovf
);
  localparam int HALF = OP_W / 2;
  localparam int DW   = 2 * OP_W;
  localparam logic [DW-1:0]   ONE_D = DW'(1);
  localparam logic [OP_W-1:0] ONE_O = OP_W'(1);
  localparam logic [DW-1:0]   LIM_H = DW'((64'd1 << (HALF - 1)) - 64'd1);
  localparam logic [DW-1:0]   LIM_F = DW'((64'd1 << (OP_W - 1)) - 64'd1);

  logic [DW-1:0]   q_s;
  logic [OP_W-1:0] r_s;
  logic [DW-1:0]   lim;
  logic            q_ovf;
  logic [HALF-1:0] qn, rn;
  logic [OP_W-1:0] qw, rw;

  always_comb begin
    q_s = neg_q ? (~qmag + ONE_D) : qmag;
    r_s = neg_r ? (~rmag + ONE_O) : rmag;
    lim = narrow ? LIM_H : LIM_F;
    if (sgn) q_ovf = neg_q ? (qmag > (lim + ONE_D)) : (qmag > lim);
    else     q_ovf = narrow ? (|qmag[DW-1:HALF]) : (|qmag[DW-1:OP_W]);

    qn = zero_div ? ~raw_dvd[OP_W-1:HALF] : q_s[HALF-1:0];
    rn = zero_div ?  raw_dvd[HALF-1:0]    : r_s[HALF-1:0];
    qw = zero_div ? ~raw_dvd[DW-1:OP_W]   : q_s[OP_W-1:0];
    rw = zero_div ?  raw_dvd[OP_W-1:0]    : r_s;

    res = narrow ? {{OP_W{1'b0}}, rn, qn} : {rw, qw};
    ovf = zero_div | q_ovf;
  end
endmodule

// File: rtl/zdiv_unit.sv
module zdiv_unit #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        size_sel_i,
  input  logic              signed_sel_i,
  input  logic [2*OP_W-1:0] dividend_i,
  input  logic [OP_W-1:0]   divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*OP_W-1:0] result_o,
  output logic              ovf_o,
  output logic              illegal_o
);
  import zdiv_pkg::*;

  localparam int DW    = 2 * OP_W;
  localparam int CNT_W = $clog2(DW + 1);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             narrow_q, sgn_q, negq_q, negr_q, zero_q;
  logic [DW-1:0]    raw_q;

  logic             narrow_in, bad_size, accept, load;
  logic [DW-1:0]    dvd_mag, quot, fix_res;
  logic [OP_W-1:0]  dvs_mag, rem;
  logic             p_negq, p_negr, p_zero, fix_ovf;

  assign narrow_in = (size_sel_i == SZ_HALF);
  assign bad_size  = size_sel_i[1];
  assign accept    = start_i && (state_q == ST_IDLE);
  assign load      = accept && !bad_size;
  assign busy_o    = (state_q != ST_IDLE);

  zdiv_sign_prep #(.OP_W(OP_W)) prep_i (
    .narrow(narrow_in), .sgn(signed_sel_i), .dividend(dividend_i),
    .divisor(divisor_i), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .neg_q(p_negq), .neg_r(p_negr), .zero_div(p_zero));

  zdiv_core #(.OP_W(OP_W)) core_i (
    .clk(clk), .rst(rst), .load(load), .step(state_q == ST_RUN),
    .narrow(narrow_in), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .quot(quot), .rem(rem));

  zdiv_sign_fix #(.OP_W(OP_W)) fix_i (
    .narrow(narrow_q), .sgn(sgn_q), .neg_q(negq_q), .neg_r(negr_q),
    .zero_div(zero_q), .raw_dvd(raw_q), .qmag(quot), .rmag(rem),
    .res(fix_res), .ovf(fix_ovf));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      narrow_q  <= 1'b0;
      sgn_q     <= 1'b0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      zero_q    <= 1'b0;
      raw_q     <= '0;
      done_o    <= 1'b0;
      result_o  <= '0;
      ovf_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && bad_size) begin
            done_o    <= 1'b1;
            illegal_o <= 1'b1;
            ovf_o     <= 1'b0;
          end else if (load) begin
            state_q  <= ST_RUN;
            cnt_q    <= narrow_in ? CNT_W'(OP_W) : CNT_W'(DW);
            narrow_q <= narrow_in;
            sgn_q    <= signed_sel_i;
            negq_q   <= p_negq;
            negr_q   <= p_negr;
            zero_q   <= p_zero;
            raw_q    <= dividend_i;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          result_o  <= fix_res;
          ovf_o     <= fix_ovf;
          illegal_o <= 1'b0;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !done_o); // R7
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !size_sel_i[1]) |=> busy_o); // R7
  AST_ILLEGAL_QUICK: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && size_sel_i[1]) |=> (done_o && illegal_o && !busy_o && $stable(result_o))); // R6
  AST_ZERO_FLAGS_OVF: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && zero_q) |-> ovf_o); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(raw_q) && $stable(zero_q))); // R8
  AST_HALF_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && narrow_q) |-> (result_o[DW-1:OP_W] == '0)); // R1
endmodule

// File: tb/zdiv_unit_tb_top.sv
`timescale 1ns/1ps
module zdiv_unit_tb_top;
  localparam int OP_W = 16;
  localparam int DW   = 2 * OP_W;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [1:0]    size_sel;
  logic          sgn;
  logic [DW-1:0] dividend;
  logic [OP_W-1:0] divisor;
  logic          busy, done, ovf, illegal;
  logic [DW-1:0] result;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  longint last_res = 0;

  always #2.5 clk = ~clk;

  zdiv_unit #(.OP_W(OP_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .size_sel_i(size_sel),
    .signed_sel_i(sgn), .dividend_i(dividend), .divisor_i(divisor),
    .busy_o(busy), .done_o(done), .result_o(result), .ovf_o(ovf),
    .illegal_o(illegal));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int sz, input bit sg, input longint dvd,
                                input longint dvs, output longint res, output bit ov);
    int n;
    longint mask, mask2, a, b, q, r, hi, lo;
    n = (sz == 1) ? OP_W : OP_W / 2;
    mask  = (64'sd1 << n) - 1;
    mask2 = (64'sd1 << (2 * n)) - 1;
    hi = (dvd >> n) & mask;
    lo = dvd & mask;
    b  = dvs & mask;
    if (b == 0) begin
      q = (~hi) & mask; r = lo; ov = 1;
    end else if (!sg) begin
      a = dvd & mask2; q = a / b; r = a % b; ov = (q > mask);
    end else begin
      a = dvd & mask2;
      if (((a >> (2 * n - 1)) & 1) != 0) a = a - (64'sd1 << (2 * n));
      if (((b >> (n - 1)) & 1) != 0) b = b - (64'sd1 << n);
      q = a / b; r = a % b;
      ov = (q > ((64'sd1 << (n - 1)) - 1)) || (q < -(64'sd1 << (n - 1)));
    end
    res = ((r & mask) << n) | (q & mask);
  endfunction

  task automatic run_op(input int sz, input bit sg, input longint dvd,
                        input longint dvs, input int poke, input string rtag);
    longint er;
    bit eo;
    int n;
    @(negedge clk);
    size_sel = 2'(sz); sgn = sg; dividend = dvd[DW-1:0]; divisor = dvs[OP_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (sz >= 2) begin
      chk(done && illegal && !busy && !ovf, "R6", "illegal flags",
          {busy, done, illegal, ovf}, 4'b0110);
      chk(result == last_res[DW-1:0], "R6", "result held", result, last_res);
      @(negedge clk);
      chk(!done, "R6", "done cleared", done, 0);
      return;
    end
    model(sz, sg, dvd, dvs, er, eo);
    n = (sz == 1) ? OP_W : OP_W / 2;
    for (int c = 0; c <= 2 * n; c++) begin
      chk(busy && !done, "R7", "busy phase", {busy, done}, 2'b10);
      if (c == poke) begin
        start = 1'b1; dividend = ~dividend; divisor = '0; sgn = ~sgn;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !busy, "R7", "done phase", {busy, done}, 2'b01);
    chk(result == er[DW-1:0], rtag, "result", result, er);
    chk(ovf == eo, rtag, "ovf", ovf, eo);
    chk(!illegal, rtag, "illegal low", illegal, 0);
    last_res = er;
    @(negedge clk);
    chk(!done && !busy, "R7", "done one cycle", {busy, done}, 2'b00);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; size_sel = 2'b00; sgn = 1'b0;
    dividend = '0; divisor = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !ovf && !illegal && result == '0, "R9", "reset state",
        {busy, done, ovf, illegal}, 0);
    chk(result == '0, "R9", "reset result", result, 0);

    // R2 plain unsigned, both sizes
    run_op(0, 0, 1000, 7, -1, "R2");
    run_op(1, 0, 100000, 300, -1, "R2");
    // R1 half mode ignores higher input bits
    run_op(0, 0, 64'hABCD_03E8, 64'hFF07, -1, "R1");
    // R3 signed sign combinations
    run_op(0, 1, -100, 7, -1, "R3");
    run_op(0, 1, 100, -7, -1, "R3");
    run_op(0, 1, -100, -7, -1, "R3");
    run_op(1, 1, -1000000, 1234, -1, "R3");
    run_op(1, 1, 1000000, -1234, -1, "R3");
    // R4 zero divisor
    run_op(0, 0, 64'h1234, 0, -1, "R4");
    run_op(1, 1, 64'h8765_4321, 0, -1, "R4");
    run_op(0, 1, 64'h00F0, 64'hAB00, -1, "R4");
    // R5 overflow and extreme signed
    run_op(0, 0, 64'hFFFF, 1, -1, "R5");
    run_op(0, 1, 64'h8000, 64'hFF, -1, "R5");
    run_op(1, 1, 64'h8000_0000, 64'hFFFF, -1, "R5");
    run_op(1, 0, 64'hFFFF_FFFF, 2, -1, "R5");
    // R6 illegal sizes
    run_op(2, 0, 55, 5, -1, "R6");
    run_op(3, 1, 55, 5, -1, "R6");
    // R8 start while busy
    run_op(0, 0, 5000, 33, 3, "R8");
    run_op(1, 1, -77777, 99, 20, "R8");
    run_op(1, 0, 123456, 789, 32, "R8");

    for (int i = 0; i < 200; i++) begin
      int sz;
      bit sg;
      longint dv, ds;
      int pick;
      sz = ($urandom % 10 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
      sg = 1'($urandom % 2);
      dv = longint'($urandom);
      pick = int'($urandom % 8);
      if (pick == 0) ds = 0;
      else if (pick == 1) ds = longint'($urandom % 4);
      else if (pick == 2) ds = 64'hFFFF;
      else ds = longint'($urandom % 65536);
      run_op(sz, sg, dv, ds, -1, sg ? "R3" : "R2");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule